// File: doc/BRIEF.md
# In-order dispatch group former

This block packs a program-ordered window of decoded operations into one dispatch group per cycle. A group has eight slots. Every operation states a slot footprint and the execution resources it needs. The former walks the window from the oldest lane upward and admits operations while they still fit. It stops at the first one that does not fit. It reports at once how many lanes it took, so the upstream queue can pop exactly that many. On the next clock edge it presents the group it formed: the slot occupancy map, the starting slot of each admitted lane, and the execution, load and store units the group uses.

The upstream side presents up to `LANES` operations each cycle with per-lane valid bits. This is the valid/ready handshake in count form: `op_take` acts as the ready. Operations not taken stay at the head of the window for the next cycle, so a blocked operation always leads the following group. The former tracks no register dependencies and models no issue queues. It does not execute anything.

Top module: `dispatch_group_former`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `grp_valid`, `grp_ops`, `grp_slot_map`, `grp_start`, `grp_exu`, `grp_ld` and `grp_st` are all zero.
- R2: `op_take` counts admitted lanes from lane 0 upward. It stops at the first lane whose `op_valid` bit is low or which does not fit. No later lane is admitted past such a lane, even if that later lane would fit.
- R3: Slot code 0 (single) takes the next free slot. Slots fill upward from slot 0. At most 8 slots are used, and bit k of `grp_slot_map` marks slot k.
- R4: Slot code 1 (pair) takes an aligned even/odd pair (0+1, 2+3, 4+5, 6+7). If the next free slot is odd, that slot is left empty and the pair takes the next even pair. If no pair is left, the operation does not fit.
- R5: Slot codes 2 and 3 (whole group) take all eight slots. Such an operation is admitted only as the first operation of a group. Later in a window it closes the group and leads the next one.
- R6: Resource code 0 takes one execution unit, the lowest-numbered free one. At most four are used per group, and bit u of `grp_exu` marks unit u.
- R7: Resource code 1 takes a free execution unit pair, units 0+1 or else 2+3. It does not fit when neither pair is wholly free.
- R8: Resource code 2 takes the lowest free load unit. At most two are used per group, and bit u of `grp_ld` marks load unit u.
- R9: Resource code 3 takes the lowest free store unit, with at most two per group (bit u of `grp_st`). Resource code 4 takes one load unit and one store unit in the same group.
- R10: Resource code 5 needs both store units free and takes both. Resource codes 6 and 7 take no unit.
- R11: One cycle after `op_take` is N>0, `grp_valid` is 1 and `grp_ops` is N. After a cycle with no admitted lane, `grp_valid` is 0 and every group output is zero. Field i of `grp_start` (bits 3i+2..3i) holds lane i's first slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | LANES | Per-lane valid, lane 0 oldest |
| op_slot | input | 2*LANES | Slot footprint code per lane |
| op_res | input | 3*LANES | Resource class code per lane |
| op_take | output | clog2(LANES+1) | Lanes admitted this cycle (combinational) |
| grp_valid | output | 1 | Registered group present |
| grp_ops | output | clog2(LANES+1) | Operations in the registered group |
| grp_slot_map | output | SLOTS | Occupied slots of the group |
| grp_start | output | 3*LANES | First slot of each admitted lane |
| grp_exu | output | EXUS | Execution units used |
| grp_ld | output | LDS | Load units used |
| grp_st | output | STS | Store units used |

## Verification
A slot limit and a unit limit can both apply within one group. The sharpest case is a pair that must skip an odd slot while a unit cap is also close. The bench sets up windows where the slot walk and the unit walk both constrain the group. It then checks that the group closes at exactly the lane the earlier limit points to, and that the later lanes, which would fit, are held back. The results are judged on the admitted count, on where the skipped odd slot appears in the slot map, and on the unit maps.

// File: rtl/dispatch_group_former.sv
module dispatch_group_former #(
  parameter int LANES = 8,
  parameter int SLOTS = 8,
  parameter int EXUS  = 4,
  parameter int LDS   = 2,
  parameter int STS   = 2,
  localparam int CW = $clog2(LANES + 1),
  localparam int SW = $clog2(SLOTS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [LANES-1:0]      op_valid,
  input  logic [2*LANES-1:0]    op_slot,
  input  logic [3*LANES-1:0]    op_res,
  output logic [CW-1:0]         op_take,
  output logic                  grp_valid,
  output logic [CW-1:0]         grp_ops,
  output logic [SLOTS-1:0]      grp_slot_map,
  output logic [SW*LANES-1:0]   grp_start,
  output logic [EXUS-1:0]       grp_exu,
  output logic [LDS-1:0]        grp_ld,
  output logic [STS-1:0]        grp_st
);

  localparam logic [1:0] SC_ONE  = 2'd0;
  localparam logic [1:0] SC_PAIR = 2'd1;

  logic [SLOTS-1:0]    map_c;
  logic [SW*LANES-1:0] start_c;
  logic [EXUS-1:0]     ex_c;
  logic [LDS-1:0]      ld_c;
  logic [STS-1:0]      st_c;
  logic [CW-1:0]       take_c;

  always_comb begin : pack
    int nxt, beg, wid, eu, ep, lu, su;
    logic ok, stop;
    logic [1:0] cls;
    logic [2:0] rc;
    map_c = '0; start_c = '0; ex_c = '0; ld_c = '0; st_c = '0; take_c = '0;
    nxt = 0; stop = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      cls = op_slot[2*i +: 2];
      rc  = op_res[3*i +: 3];
      beg = (cls == SC_ONE) ? nxt : (cls == SC_PAIR) ? ((nxt + 1) / 2) * 2 : 0;
      wid = (cls == SC_ONE) ? 1 : (cls == SC_PAIR) ? 2 : SLOTS;
      eu = -1; ep = -1; lu = -1; su = -1;
      for (int u = EXUS - 1; u >= 0; u--) if (!ex_c[u]) eu = u;
      for (int u = EXUS - 2; u >= 0; u -= 2) if (!ex_c[u] && !ex_c[u+1]) ep = u;
      for (int u = LDS - 1; u >= 0; u--) if (!ld_c[u]) lu = u;
      for (int u = STS - 1; u >= 0; u--) if (!st_c[u]) su = u;
      ok = op_valid[i] && !stop && (beg + wid <= SLOTS) && !(cls[1] && nxt != 0);
      case (rc)
        3'd0: ok = ok && (eu >= 0);
        3'd1: ok = ok && (ep >= 0);
        3'd2: ok = ok && (lu >= 0);
        3'd3: ok = ok && (su >= 0);
        3'd4: ok = ok && (lu >= 0) && (su >= 0);
        3'd5: ok = ok && (st_c == '0);
        default: ;
      endcase
      if (ok) begin
        case (rc)
          3'd0: ex_c[eu] = 1'b1;
          3'd1: begin ex_c[ep] = 1'b1; ex_c[ep+1] = 1'b1; end
          3'd2: ld_c[lu] = 1'b1;
          3'd3: st_c[su] = 1'b1;
          3'd4: begin ld_c[lu] = 1'b1; st_c[su] = 1'b1; end
          3'd5: st_c = '1;
          default: ;
        endcase
        for (int k = 0; k < SLOTS; k++)
          if (k >= beg && k < beg + wid) map_c[k] = 1'b1;
        start_c[SW*i +: SW] = SW'(beg);
        take_c = take_c + CW'(1);
        nxt = beg + wid;
      end else begin
        stop = 1'b1;
      end
    end
  end

  assign op_take = take_c;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grp_valid <= 1'b0; grp_ops <= '0; grp_slot_map <= '0; grp_start <= '0;
      grp_exu <= '0; grp_ld <= '0; grp_st <= '0;
    end else begin
      grp_valid    <= (take_c != '0);
      grp_ops      <= take_c;
      grp_slot_map <= map_c;
      grp_start    <= start_c;
      grp_exu      <= ex_c;
      grp_ld       <= ld_c;
      grp_st       <= st_c;
    end
  end

  p_take_needs_head_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_take != '0) |-> op_valid[0]);

  p_group_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (op_take != '0) |=> (grp_valid && grp_ops == $past(op_take)));

  p_idle_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !grp_valid |-> (grp_slot_map == '0 && grp_exu == '0 && grp_ld == '0 && grp_st == '0));

  p_slot0_used_r3: assert property (@(posedge clk) disable iff (!rst_n)
    grp_valid |-> grp_slot_map[0]);

  for (genvar k = 0; k + 1 < SLOTS; k += 2) begin : g_hole
    p_holes_odd_r4: assert property (@(posedge clk) disable iff (!rst_n)
      grp_slot_map[k+1] |-> grp_slot_map[k]);
  end

endmodule

// File: tb/dispatch_group_former_test.sv
module dispatch_group_former_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  op_valid = '0;
  logic [15:0] op_slot = '0;
  logic [23:0] op_res = '0;
  logic [3:0]  op_take;
  logic        grp_valid;
  logic [3:0]  grp_ops;
  logic [7:0]  grp_slot_map;
  logic [23:0] grp_start;
  logic [3:0]  grp_exu;
  logic [1:0]  grp_ld;
  logic [1:0]  grp_st;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  dispatch_group_former uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_slot(op_slot), .op_res(op_res),
    .op_take(op_take), .grp_valid(grp_valid), .grp_ops(grp_ops), .grp_slot_map(grp_slot_map),
    .grp_start(grp_start), .grp_exu(grp_exu), .grp_ld(grp_ld), .grp_st(grp_st));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(int i, logic [1:0] c, logic [2:0] r);
    op_valid[i] = 1'b1;
    op_slot[2*i +: 2] = c;
    op_res[3*i +: 3] = r;
  endtask

  task automatic clear();
    op_valid = '0; op_slot = '0; op_res = '0;
  endtask

  task automatic run(string req, int take, logic [7:0] map, logic [3:0] ex,
                     logic [1:0] ld, logic [1:0] st);
    #1;
    check({req, " take"}, op_take, take);
    @(negedge clk);
    check({req, " valid"}, grp_valid, take != 0);
    check({req, " ops"}, grp_ops, take);
    check({req, " map"}, grp_slot_map, map);
    check({req, " exu"}, grp_exu, ex);
    check({req, " ld"}, grp_ld, ld);
    check({req, " st"}, grp_st, st);
    clear();
  endtask

  task automatic t_reset();
    check("R1 valid", grp_valid, 0);
    check("R1 map", grp_slot_map, 0);
    check("R1 units", {grp_exu, grp_ld, grp_st}, 0);
    check("R1 start", grp_start, 0);
  endtask

  task automatic t_exu_cap();
    for (int i = 0; i < 8; i++) put(i, 0, 0);
    run("R6 exu cap", 4, 8'h0F, 4'hF, 0, 0);
  endtask

  task automatic t_all_singles();
    for (int i = 0; i < 8; i++) put(i, 0, 6);
    run("R3 eight singles", 8, 8'hFF, 0, 0, 0);
  endtask

  task automatic t_pair_skip();
    put(0, 0, 0); put(1, 1, 2); put(2, 0, 3); put(3, 1, 6); put(4, 0, 6);
    #1; check("R4 starts before edge", op_take, 4);
    run("R4 pair skip", 4, 8'hDD, 4'h1, 2'b01, 2'b01);
  endtask

  task automatic t_pair_start();
    put(0, 0, 0); put(1, 1, 2); put(2, 0, 3); put(3, 1, 6);
    #1;
    @(negedge clk);
    check("R11 start fields", grp_start, 24'h000D10);
    clear();
  endtask

  task automatic t_pair_end();
    for (int i = 0; i < 7; i++) put(i, 0, 7);
    put(7, 1, 6);
    run("R4 pair no room", 7, 8'h7F, 0, 0, 0);
  endtask

  task automatic t_whole();
    put(0, 0, 0); put(1, 2, 0);
    run("R5 whole closes group", 1, 8'h01, 4'h1, 0, 0);
    put(0, 3, 0); put(1, 0, 0);
    run("R5 whole alone", 1, 8'hFF, 4'h1, 0, 0);
  endtask

  task automatic t_double_exu();
    put(0, 0, 0); put(1, 0, 1); put(2, 0, 1);
    run("R7 exu pair", 2, 8'h03, 4'hD, 0, 0);
  endtask

  task automatic t_loads();
    put(0, 0, 2); put(1, 0, 2); put(2, 0, 2); put(3, 0, 0);
    run("R8 load cap and R2 no passing", 2, 8'h03, 0, 2'b11, 0);
  endtask

  task automatic t_ld_st();
    put(0, 0, 4); put(1, 0, 3); put(2, 0, 3);
    run("R9 load plus store pipe", 2, 8'h03, 0, 2'b01, 2'b11);
  endtask

  task automatic t_both_st();
    put(0, 0, 3); put(1, 0, 5);
    run("R10 both stores blocked", 1, 8'h01, 0, 0, 2'b01);
    put(0, 1, 5); put(1, 0, 3);
    run("R10 both stores", 1, 8'h03, 0, 0, 2'b11);
  endtask

  task automatic t_gap();
    put(0, 0, 0); put(2, 0, 0);
    op_valid[1] = 1'b0;
    run("R2 valid gap", 1, 8'h01, 4'h1, 0, 0);
  endtask

  task automatic t_idle();
    run("R11 idle", 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_exu_cap();
    t_all_singles();
    t_pair_skip();
    t_pair_start();
    t_pair_end();
    t_whole();
    t_double_exu();
    t_loads();
    t_ld_st();
    t_both_st();
    t_gap();
    t_idle();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule